// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits in front of the arithmetic datapath of a fused multiply-add unit that computes z + x*y on binary floating-point operands (double precision by default). It sorts each of the three operands into a class and decides whether the result follows from the classes alone: NaN propagation, invalid combinations of infinities and zeros, infinite results, and sums in which the product is an exact zero. When it does, the block raises a bypass flag and supplies the final encoding and the invalid-operation flag. The datapath can then skip multiplication, alignment and rounding.

Two negate controls produce the four fused variants: multiply-add (neither set), multiply-subtract (addend negated), negated multiply-subtract (product negated) and negated multiply-add (both negated). The block always outputs the effective product sign and the effective addend sign, so the datapath can use them. A round-down control selects the sign of an exact zero that comes from adding opposite-signed zeros. All outputs are registered one cycle after the inputs.

Top module: `fma_special_resolver`

## Requirements
- R1: One cycle after the inputs, prod_sign equals sign(x) XOR sign(y) XOR neg_prod, and add_sign equals sign(z) XOR neg_add. The sign is bit 63.
- R2: An operand is a signalling NaN when its exponent field (bits 62:52) is all ones, its fraction bit 51 is 0 and its fraction is nonzero. When any operand is a signalling NaN, the first such operand in the order z, x, y is returned with fraction bit 51 set, and invalid is raised.
- R3: An operand is a quiet NaN when its exponent is all ones and fraction bit 51 is 1. With no signalling NaN present, the first quiet NaN in the order z, x, y is returned unchanged, and invalid stays low.
- R4: With no NaN present, infinity times zero (in either order) raises invalid and returns the default NaN 0x7FF8000000000000.
- R5: If the product is infinite and z is an infinity whose effective sign differs from the product sign, the block raises invalid and returns the default NaN. Otherwise an infinite product returns an infinity carrying the product sign.
- R6: If the product is zero and z is nonzero, the result is z's magnitude with the effective addend sign. This covers an infinite z.
- R7: If the product is zero, z is zero and the effective signs agree, the result is a zero with that sign. If the signs differ, the result is +0, or -0 when rnd_down is 1.
- R8: If the product is finite and nonzero and z is infinite, the result is an infinity with the effective addend sign.
- R9: If all three operands are finite and nonzero, byp_valid, invalid and byp_result are all 0.
- R10: Every bypass result sets byp_valid. Invalid is never raised without byp_valid. While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Negate the product |
| neg_add | input | 1 | Negate the addend |
| rnd_down | input | 1 | Rounding toward minus infinity is active |
| byp_valid | output | 1 | The result bypasses the datapath |
| byp_result | output | 64 | Bypass result encoding |
| invalid | output | 1 | Invalid-operation flag |
| prod_sign | output | 1 | Effective product sign |
| add_sign | output | 1 | Effective addend sign |

## Verification
The properties assume that every input is held stable for at least one rising edge and that each value is a legal bit pattern. The block has no don't-care inputs, so any 64-bit value is acceptable. They do not assume that the operand classes are spread evenly. The stimulus therefore picks a class for each operand first, then random fields inside that class. This puts NaNs, infinities and zeros far more often than uniform bits would, and it checks all of them against a reference model written from the requirements. Directed vectors cover NaN priority ties, the signed-zero sums under both rounding settings, and the infinity conflicts under all four negate combinations.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_QNAN = 3'd4,
      CLS_SNAN = 3'd5
   } opclass_e;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
   import fma_sc_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] operand,
   output opclass_e     cls
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = operand[W-2:FRAC_W];
   assign frac_f = operand[FRAC_W-1:0];

   always_comb begin
      if (&exp_f) begin
         if (frac_f == '0)           cls = CLS_INF;
         else if (frac_f[FRAC_W-1])  cls = CLS_QNAN;
         else                        cls = CLS_SNAN;
      end else if (exp_f == '0) begin
         cls = (frac_f == '0) ? CLS_ZERO : CLS_SUB;
      end else begin
         cls = CLS_NORM;
      end
   end
endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
   import fma_sc_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] z_op,
   input  logic [W-1:0] x_op,
   input  logic [W-1:0] y_op,
   input  opclass_e     z_cls,
   input  opclass_e     x_cls,
   input  opclass_e     y_cls,
   output logic         nan_hit,
   output logic         nan_sig,
   output logic [W-1:0] nan_val
);
   localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

   always_comb begin
      nan_hit = 1'b1;
      nan_sig = 1'b1;
      nan_val = '0;
      if (z_cls == CLS_SNAN)       nan_val = z_op | QUIET_BIT;
      else if (x_cls == CLS_SNAN)  nan_val = x_op | QUIET_BIT;
      else if (y_cls == CLS_SNAN)  nan_val = y_op | QUIET_BIT;
      else begin
         nan_sig = 1'b0;
         if (z_cls == CLS_QNAN)       nan_val = z_op;
         else if (x_cls == CLS_QNAN)  nan_val = x_op;
         else if (y_cls == CLS_QNAN)  nan_val = y_op;
         else                         nan_hit = 1'b0;
      end
   end
endmodule

// File: rtl/fma_sc_decide.sv
module fma_sc_decide
   import fma_sc_pkg::*;
#(
   parameter int EXP_W              = 11,
   parameter int FRAC_W             = 52,
   localparam int W                 = 1 + EXP_W + FRAC_W,
   parameter logic [W-1:0] DEF_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
   input  opclass_e     z_cls,
   input  opclass_e     x_cls,
   input  opclass_e     y_cls,
   input  logic [W-2:0] z_mag,
   input  logic         p_sign,
   input  logic         a_sign,
   input  logic         rnd_down,
   output logic         spc_hit,
   output logic         spc_inv,
   output logic [W-1:0] spc_val
);
   localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

   logic x_zero, y_zero, x_inf, y_inf, z_zero, z_inf;
   logic inf_times_zero, prod_inf, prod_zero;

   assign x_zero = (x_cls == CLS_ZERO);
   assign y_zero = (y_cls == CLS_ZERO);
   assign x_inf  = (x_cls == CLS_INF);
   assign y_inf  = (y_cls == CLS_INF);
   assign z_zero = (z_cls == CLS_ZERO);
   assign z_inf  = (z_cls == CLS_INF);

   assign inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
   assign prod_inf       = x_inf || y_inf;
   assign prod_zero      = x_zero || y_zero;

   always_comb begin
      spc_hit = 1'b1;
      spc_inv = 1'b0;
      spc_val = '0;
      if (inf_times_zero) begin
         spc_inv = 1'b1;
         spc_val = DEF_NAN;
      end else if (prod_inf) begin
         if (z_inf && (a_sign != p_sign)) begin
            spc_inv = 1'b1;
            spc_val = DEF_NAN;
         end else begin
            spc_val = {p_sign, INF_MAG};
         end
      end else if (prod_zero) begin
         if (z_zero && (a_sign != p_sign)) spc_val = {rnd_down, {(W-1){1'b0}}};
         else                              spc_val = {a_sign, z_mag};
      end else if (z_inf) begin
         spc_val = {a_sign, INF_MAG};
      end else begin
         spc_hit = 1'b0;
      end
   end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
   import fma_sc_pkg::*;
#(
   parameter int EXP_W              = 11,
   parameter int FRAC_W             = 52,
   localparam int W                 = 1 + EXP_W + FRAC_W,
   parameter logic [W-1:0] DEF_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] op_z,
   input  logic [W-1:0] op_x,
   input  logic [W-1:0] op_y,
   input  logic         neg_prod,
   input  logic         neg_add,
   input  logic         rnd_down,
   output logic         byp_valid,
   output logic [W-1:0] byp_result,
   output logic         invalid,
   output logic         prod_sign,
   output logic         add_sign
);
   localparam int N_OPS = 3;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_width
      $error("fma_special_resolver: EXP_W and FRAC_W must each be at least 2");
   end
   if (!(&DEF_NAN[W-2:FRAC_W]) || !DEF_NAN[FRAC_W-1]) begin : g_bad_nan
      $error("fma_special_resolver: DEF_NAN must encode a quiet NaN");
   end

   logic [W-1:0] ops [N_OPS];
   opclass_e     cls [N_OPS];

   assign ops[0] = op_z;
   assign ops[1] = op_x;
   assign ops[2] = op_y;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .operand (ops[i]),
         .cls     (cls[i])
      );
   end

   logic         p_sign_c, a_sign_c;
   logic         nan_hit, nan_sig, spc_hit, spc_inv;
   logic [W-1:0] nan_val, spc_val;

   assign p_sign_c = op_x[W-1] ^ op_y[W-1] ^ neg_prod;
   assign a_sign_c = op_z[W-1] ^ neg_add;

   fma_sc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
      .z_op    (op_z),
      .x_op    (op_x),
      .y_op    (op_y),
      .z_cls   (cls[0]),
      .x_cls   (cls[1]),
      .y_cls   (cls[2]),
      .nan_hit (nan_hit),
      .nan_sig (nan_sig),
      .nan_val (nan_val)
   );

   fma_sc_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEF_NAN(DEF_NAN)) u_dec (
      .z_cls    (cls[0]),
      .x_cls    (cls[1]),
      .y_cls    (cls[2]),
      .z_mag    (op_z[W-2:0]),
      .p_sign   (p_sign_c),
      .a_sign   (a_sign_c),
      .rnd_down (rnd_down),
      .spc_hit  (spc_hit),
      .spc_inv  (spc_inv),
      .spc_val  (spc_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byp_valid  <= 1'b0;
         byp_result <= '0;
         invalid    <= 1'b0;
         prod_sign  <= 1'b0;
         add_sign   <= 1'b0;
      end else begin
         prod_sign <= p_sign_c;
         add_sign  <= a_sign_c;
         if (nan_hit) begin
            byp_valid  <= 1'b1;
            byp_result <= nan_val;
            invalid    <= nan_sig;
         end else begin
            byp_valid  <= spc_hit;
            byp_result <= spc_val;
            invalid    <= spc_inv;
         end
      end
   end
endmodule

// File: rtl/fma_sc_checker.sv
module fma_sc_checker #(
   parameter int EXP_W              = 11,
   parameter int FRAC_W             = 52,
   localparam int W                 = 1 + EXP_W + FRAC_W,
   parameter logic [W-1:0] DEF_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] op_z,
   input logic [W-1:0] op_x,
   input logic [W-1:0] op_y,
   input logic         neg_prod,
   input logic         neg_add,
   input logic         rnd_down,
   input logic         byp_valid,
   input logic [W-1:0] byp_result,
   input logic         invalid,
   input logic         prod_sign,
   input logic         add_sign
);
   localparam logic [W-1:0] QMASK = W'(1) << (FRAC_W - 1);

   function automatic logic is_nan(input logic [W-1:0] v);
      return (&v[W-2:FRAC_W]) && (v[FRAC_W-1:0] != '0);
   endfunction
   function automatic logic is_snan(input logic [W-1:0] v);
      return is_nan(v) && !v[FRAC_W-1];
   endfunction
   function automatic logic is_inf(input logic [W-1:0] v);
      return (&v[W-2:FRAC_W]) && (v[FRAC_W-1:0] == '0);
   endfunction
   function automatic logic is_zero(input logic [W-1:0] v);
      return v[W-2:0] == '0;
   endfunction
   function automatic logic is_fin_nz(input logic [W-1:0] v);
      return !(&v[W-2:FRAC_W]) && !is_zero(v);
   endfunction

   logic any_nan, any_snan;
   assign any_nan  = is_nan(op_z) || is_nan(op_x) || is_nan(op_y);
   assign any_snan = is_snan(op_z) || is_snan(op_x) || is_snan(op_y);

   // R1: effective signs follow the inputs by one cycle
   p_sign_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (prod_sign == ($past(op_x[W-1]) ^ $past(op_y[W-1]) ^ $past(neg_prod)))
            && (add_sign == ($past(op_z[W-1]) ^ $past(neg_add))));

   // R2: signalling NaN in z wins and is quieted
   p_snan_z_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_snan(op_z) |=> byp_valid && invalid && (byp_result == ($past(op_z) | QMASK)));

   // R3: quiet NaN in z passes unchanged without invalid
   p_qnan_z_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_snan && is_nan(op_z)) |=> byp_valid && !invalid && (byp_result == $past(op_z)));

   // R4: infinity times zero gives the default NaN
   p_inf_times_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_nan && ((is_inf(op_x) && is_zero(op_y)) || (is_zero(op_x) && is_inf(op_y))))
      |=> invalid && (byp_result == DEF_NAN));

   // R9: all-finite nonzero operands never bypass
   p_finite_no_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_fin_nz(op_z) && is_fin_nz(op_x) && is_fin_nz(op_y)) |=> !byp_valid && !invalid);

   // R10: invalid always comes with a bypass result
   p_invalid_has_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> byp_valid);
endmodule

bind fma_special_resolver fma_sc_checker #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEF_NAN(DEF_NAN)
) u_fma_sc_checker (.*);

// File: tb/tb_fma_special_resolver.sv
module tb_fma_special_resolver;
   localparam int W = 64;
   localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] QB   = 64'h0008_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_z = '0, op_x = '0, op_y = '0;
   logic        neg_prod = 1'b0, neg_add = 1'b0, rnd_down = 1'b0;
   logic        byp_valid, invalid, prod_sign, add_sign;
   logic [63:0] byp_result;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   fma_special_resolver dut (
      .clk(clk), .rst_n(rst_n), .op_z(op_z), .op_x(op_x), .op_y(op_y),
      .neg_prod(neg_prod), .neg_add(neg_add), .rnd_down(rnd_down),
      .byp_valid(byp_valid), .byp_result(byp_result), .invalid(invalid),
      .prod_sign(prod_sign), .add_sign(add_sign)
   );

   // class codes used only by the bench: 0 zero, 1 sub, 2 norm, 3 inf, 4 qnan, 5 snan
   function automatic int cls_of(input logic [63:0] v);
      if (v[62:52] == 11'h7FF) begin
         if (v[51:0] == '0) return 3;
         return v[51] ? 4 : 5;
      end
      if (v[62:52] == '0) return (v[51:0] == '0) ? 0 : 1;
      return 2;
   endfunction

   function automatic logic [63:0] make_op(input int c);
      logic s;
      logic [51:0] f;
      s = 1'($urandom);
      f = {20'($urandom), 32'($urandom)};
      case (c)
         0:       return {s, 63'd0};
         1:       return {s, 11'd0, f | 52'd1};
         2:       return {s, 11'(1 + $urandom % 2046), f};
         3:       return {s, 11'h7FF, 52'd0};
         4:       return {s, 11'h7FF, 1'b1, f[50:0]};
         default: return {s, 11'h7FF, 1'b0, f[50:0] | 51'd1};
      endcase
   endfunction

   function automatic void model(
      input  logic [63:0] z, x, y,
      input  logic np, na, rd,
      output logic ev, output logic [63:0] er, output logic ei,
      output logic eps, output logic eas, output string tag);
      int cz, cx, cy;
      logic pinf, pzero;
      cz = cls_of(z); cx = cls_of(x); cy = cls_of(y);
      eps = x[63] ^ y[63] ^ np;
      eas = z[63] ^ na;
      ev = 1'b1; ei = 1'b0; er = '0;
      pinf  = (cx == 3) || (cy == 3);
      pzero = (cx == 0) || (cy == 0);
      if (cz == 5)      begin er = z | QB; ei = 1'b1; tag = "R2"; end
      else if (cx == 5) begin er = x | QB; ei = 1'b1; tag = "R2"; end
      else if (cy == 5) begin er = y | QB; ei = 1'b1; tag = "R2"; end
      else if (cz == 4) begin er = z; tag = "R3"; end
      else if (cx == 4) begin er = x; tag = "R3"; end
      else if (cy == 4) begin er = y; tag = "R3"; end
      else if (pinf && pzero) begin er = DNAN; ei = 1'b1; tag = "R4"; end
      else if (pinf) begin
         tag = "R5";
         if (cz == 3 && eas != eps) begin er = DNAN; ei = 1'b1; end
         else er = {eps, 11'h7FF, 52'd0};
      end else if (pzero) begin
         if (cz == 0) begin
            tag = "R7";
            er = (eas == eps) ? {eas, 63'd0} : {rd, 63'd0};
         end else begin
            tag = "R6";
            er = {eas, z[62:0]};
         end
      end else if (cz == 3) begin er = {eas, 11'h7FF, 52'd0}; tag = "R8"; end
      else begin ev = 1'b0; tag = "R9"; end
   endfunction

   task automatic run_vec(input logic [63:0] z, x, y, input logic np, na, rd);
      logic ev, ei, eps, eas;
      logic [63:0] er;
      string tag;
      @(negedge clk);
      op_z = z; op_x = x; op_y = y; neg_prod = np; neg_add = na; rnd_down = rd;
      model(z, x, y, np, na, rd, ev, er, ei, eps, eas, tag);
      @(negedge clk);
      n_chk++;
      if (byp_valid !== ev || byp_result !== er || invalid !== ei) begin
         n_fail++;
         $display("FAIL %s (R10 flags): got v=%0b r=%h i=%0b expected v=%0b r=%h i=%0b",
                  tag, byp_valid, byp_result, invalid, ev, er, ei);
      end
      n_chk++;
      if (prod_sign !== eps || add_sign !== eas) begin
         n_fail++;
         $display("FAIL R1: got ps=%0b as=%0b expected ps=%0b as=%0b",
                  prod_sign, add_sign, eps, eas);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      n_chk++;
      if (byp_valid !== 1'b0 || byp_result !== '0 || invalid !== 1'b0 ||
          prod_sign !== 1'b0 || add_sign !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: got v=%0b r=%h i=%0b expected all zero",
                  byp_valid, byp_result, invalid);
      end
      rst_n = 1'b1;

      // R2 priority: sNaN in x beats qNaN in z; sNaN in z beats sNaN in y
      run_vec(64'h7FF8_0000_0000_0001, 64'h7FF0_0000_0000_0002, 64'h3FF0_0000_0000_0000, 0, 0, 0);
      run_vec(64'hFFF0_0000_0000_0005, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0009, 0, 0, 0);
      // R3 priority: qNaN in x before qNaN in y
      run_vec(64'h4000_0000_0000_0000, 64'h7FF8_0000_0000_00AA, 64'hFFF8_0000_0000_00BB, 0, 0, 0);
      // R4 both orders
      run_vec(64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 0);
      run_vec(64'h3FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1, 1, 0);
      // R5 conflict and agreement across negate variants
      for (int m = 0; m < 4; m++) begin
         run_vec(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                 1'(m >> 1), 1'(m), 0);
      end
      // R6 zero product with finite and infinite z, msub
      run_vec(64'h4010_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 1, 0);
      run_vec(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 1, 0);
      // R7 signed zeros under both rounding settings
      for (int m = 0; m < 16; m++) begin
         run_vec({1'(m), 63'd0}, 64'h0000_0000_0000_0000, 64'h4000_0000_0000_0000,
                 1'(m >> 1), 1'(m >> 2), 1'(m >> 3));
      end
      // R8 finite product with infinite z
      run_vec(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h4000_0000_0000_0000, 0, 1, 0);
      // R9 finite nonzero operands
      run_vec(64'h3FF0_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hC000_0000_0000_0000, 1, 0, 1);

      // class-weighted random vectors
      for (int i = 0; i < 3000; i++) begin
         run_vec(make_op($urandom % 6), make_op($urandom % 6), make_op($urandom % 6),
                 1'($urandom), 1'($urandom), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule